// File: doc/BRIEF.md
# Bus Master First-Data Watchdog

This block guards the opening of a shared-bus transaction that a master has started. When the transaction-start strobe arrives it captures a 3-bit timeout code. If the code is nonzero it arms a counter that advances once per bus clock. If the first data phase completes, or the transaction ends, before the limit is reached, the counter stops and nothing is signalled. If the limit is reached first, the block raises a one-cycle disconnect pulse, which tells the surrounding bus logic to cut the stalled master off.

The limit is set in coarse steps. Code N selects N steps of `STEP_CYC` bus clocks, which is 32 by default. Code zero turns the watchdog off. The busy flag is high while the timer is armed and counting. The block does no protocol decoding, no retry handling and no data movement. It only sees strobes from the bus engine that owns those functions.

Top module: `fdata_wdog`

## Requirements
- R1: A synchronous active-high reset clears the block. After the reset edge `busy_o` and `disc_o` are both 0, and any count that was running is dropped, so no disconnect follows.
- R2: A transaction started with code 0 leaves the timer disarmed. `busy_o` stays 0 and `disc_o` never rises for that transaction.
- R3: A transaction started with code N (1 to 7) and no stop raises `disc_o` after exactly N×32 rising edges, counted from the edge that sampled `txn_start_i`.
- R4: `disc_o` is high for exactly one cycle and at most once per transaction. `busy_o` is 0 in the cycle that `disc_o` is high.
- R5: `first_done_i` sampled on an edge before expiry disarms the timer. `busy_o` is 0 after that edge and no disconnect is issued for that transaction.
- R6: `txn_end_i` sampled before expiry disarms the timer in the same way as first-data completion.
- R7: The code is captured only on the edge that samples `txn_start_i`. Changing `tmo_code_i` later in the transaction does not change when, or whether, the disconnect occurs.
- R8: A new `txn_start_i` while armed restarts the count from zero with the newly sampled code. The earlier deadline is dropped.
- R9: If a stop strobe (`first_done_i` or `txn_end_i`) is sampled on the same edge at which the limit would expire, the stop wins and no disconnect is issued.
- R10: If `txn_start_i` and a stop strobe are sampled on the same edge, the start wins. The timer arms with the new code and `busy_o` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| txn_start_i | input | 1 | One-cycle strobe: a master began a transaction |
| first_done_i | input | 1 | One-cycle strobe: the first data phase completed |
| txn_end_i | input | 1 | One-cycle strobe: the transaction finished |
| tmo_code_i | input | CODE_W (3) | Timeout code: 0 disables, N gives N×STEP_CYC clocks |
| disc_o | output | 1 | One-cycle disconnect request |
| busy_o | output | 1 | Timer armed and counting |

## Verification
The bench builds the block with its default values: a 3-bit code and a 32-clock step. This keeps the longest limit, code 7, at 224 cycles, so every code value can be run to full expiry within the run budget. It also lets the bench place a stop strobe exactly on the expiry edge and one cycle on either side of it. The power-of-two step selects the shift variant of the limit decoder, so the bench exercises that variant. Directed cases then cover reset in the middle of a count, restart while armed, and a start that coincides with a stop.

// File: rtl/fdata_wdog_pkg.sv
package fdata_wdog_pkg;

   typedef enum logic {
      WD_IDLE  = 1'b0,
      WD_ARMED = 1'b1
   } wd_state_e;

   // Width needed to hold the largest limit (all-ones code times step).
   function automatic int lim_width(input int code_w, input int step_cyc);
      longint max_lim;
      int     w;
      max_lim = ((longint'(1) << code_w) - 1) * longint'(step_cyc);
      w = 1;
      while ((longint'(1) << w) <= max_lim) w++;
      return w;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int log2_floor(input int v);
      int r;
      r = 0;
      while ((v >> (r + 1)) > 0) r++;
      return r;
   endfunction

endpackage

// File: rtl/fdata_wdog_limit_dec.sv
module fdata_wdog_limit_dec
   import fdata_wdog_pkg::*;
#(
   parameter int CODE_W   = 3,
   parameter int STEP_CYC = 32,
   parameter int LIM_W    = 8
) (
   input  logic [CODE_W-1:0] code_i,
   output logic              enable_o,
   output logic [LIM_W-1:0]  term_o
);

   localparam bit STEP_P2   = is_pow2(STEP_CYC);
   localparam int STEP_LOG2 = log2_floor(STEP_CYC);

   logic [LIM_W-1:0] code_ext;
   logic [LIM_W-1:0] limit;

   assign code_ext = LIM_W'(code_i);
   assign enable_o = |code_i;

   generate
      if (STEP_P2) begin : g_shift
         assign limit = code_ext << STEP_LOG2;
      end else begin : g_mult
         assign limit = code_ext * LIM_W'(STEP_CYC);
      end
   endgenerate

   // Terminal count is one below the limit; unused when disabled.
   assign term_o = limit - LIM_W'(1);

endmodule

// File: rtl/fdata_wdog_ctr.sv
module fdata_wdog_ctr #(
   parameter int LIM_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [LIM_W-1:0] term_i,
   output logic             hit_o
);

   logic [LIM_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= cnt_q + LIM_W'(1);
      end
   end

   assign hit_o = en_i && (cnt_q == term_i);

endmodule

// File: rtl/fdata_wdog_ctrl.sv
module fdata_wdog_ctrl
   import fdata_wdog_pkg::*;
#(
   parameter int LIM_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             arm_en_i,
   input  logic [LIM_W-1:0] term_in_i,
   input  logic             hit_i,
   output logic             armed_o,
   output logic [LIM_W-1:0] term_o,
   output logic             disc_o
);

   wd_state_e        state_q, state_d;
   logic [LIM_W-1:0] term_q;
   logic             disc_q, disc_d;

   always_comb begin
      state_d = state_q;
      disc_d  = 1'b0;
      if (start_i) begin
         state_d = arm_en_i ? WD_ARMED : WD_IDLE;
      end else if (state_q == WD_ARMED) begin
         if (stop_i) begin
            state_d = WD_IDLE;
         end else if (hit_i) begin
            state_d = WD_IDLE;
            disc_d  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= WD_IDLE;
         disc_q  <= 1'b0;
         term_q  <= '0;
      end else begin
         state_q <= state_d;
         disc_q  <= disc_d;
         if (start_i) term_q <= term_in_i;
      end
   end

   assign armed_o = (state_q == WD_ARMED);
   assign term_o  = term_q;
   assign disc_o  = disc_q;

endmodule

// File: rtl/fdata_wdog.sv
module fdata_wdog
   import fdata_wdog_pkg::*;
#(
   parameter int CODE_W   = 3,
   parameter int STEP_CYC = 32
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              txn_start_i,
   input  logic              first_done_i,
   input  logic              txn_end_i,
   input  logic [CODE_W-1:0] tmo_code_i,
   output logic              disc_o,
   output logic              busy_o
);

   localparam int LIM_W = lim_width(CODE_W, STEP_CYC);

   generate
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code_w
         $error("fdata_wdog: CODE_W must lie in 1..8");
      end
      if (STEP_CYC < 1) begin : g_bad_step
         $error("fdata_wdog: STEP_CYC must be positive");
      end
      if (LIM_W > 32) begin : g_bad_lim
         $error("fdata_wdog: limit width exceeds 32 bits");
      end
   endgenerate

   logic             arm_en;
   logic [LIM_W-1:0] term_dec;
   logic [LIM_W-1:0] term_run;
   logic             armed;
   logic             hit;
   logic             stop;

   assign stop = first_done_i | txn_end_i;

   fdata_wdog_limit_dec #(
      .CODE_W   (CODE_W),
      .STEP_CYC (STEP_CYC),
      .LIM_W    (LIM_W)
   ) u_dec (
      .code_i   (tmo_code_i),
      .enable_o (arm_en),
      .term_o   (term_dec)
   );

   fdata_wdog_ctr #(
      .LIM_W (LIM_W)
   ) u_ctr (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .clr_i  (txn_start_i),
      .en_i   (armed),
      .term_i (term_run),
      .hit_o  (hit)
   );

   fdata_wdog_ctrl #(
      .LIM_W (LIM_W)
   ) u_ctrl (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .start_i   (txn_start_i),
      .stop_i    (stop),
      .arm_en_i  (arm_en),
      .term_in_i (term_dec),
      .hit_i     (hit),
      .armed_o   (armed),
      .term_o    (term_run),
      .disc_o    (disc_o)
   );

   assign busy_o = armed;

endmodule

// File: rtl/fdata_wdog_chk.sv
module fdata_wdog_chk #(
   parameter int CODE_W = 3
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              txn_start_i,
   input logic              first_done_i,
   input logic              txn_end_i,
   input logic [CODE_W-1:0] tmo_code_i,
   input logic              disc_o,
   input logic              busy_o
);

   AST_RESET_IDLE: assert property (@(posedge clk_i)
      rst_i |=> (!busy_o && !disc_o)); // R1

   AST_OFF_CODE_DISARMED: assert property (@(posedge clk_i) disable iff (rst_i)
      (txn_start_i && tmo_code_i == '0) |=> (!busy_o && !disc_o)); // R2

   AST_DISC_AFTER_ARMED: assert property (@(posedge clk_i) disable iff (rst_i)
      disc_o |-> $past(busy_o)); // R3

   AST_DISC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      disc_o |=> !disc_o); // R4

   AST_DISC_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
      disc_o |-> !busy_o); // R4

   AST_FIRST_DATA_STOPS: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_o && first_done_i && !txn_start_i) |=> (!busy_o && !disc_o)); // R5

   AST_END_STOPS: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_o && txn_end_i && !txn_start_i) |=> (!busy_o && !disc_o)); // R6

   AST_START_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
      (txn_start_i && tmo_code_i != '0) |=> (busy_o && !disc_o)); // R10

endmodule

bind fdata_wdog fdata_wdog_chk #(
   .CODE_W (CODE_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .txn_start_i  (txn_start_i),
   .first_done_i (first_done_i),
   .txn_end_i    (txn_end_i),
   .tmo_code_i   (tmo_code_i),
   .disc_o       (disc_o),
   .busy_o       (busy_o)
);

// File: tb/fdata_wdog_tb.sv
module fdata_wdog_tb;

   logic       clk = 1'b0;
   logic       rst;
   logic       txn_start;
   logic       first_done;
   logic       txn_end;
   logic [2:0] code;
   logic       disc;
   logic       busy;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk; // 250 MHz

   fdata_wdog u_dut (
      .clk_i        (clk),
      .rst_i        (rst),
      .txn_start_i  (txn_start),
      .first_done_i (first_done),
      .txn_end_i    (txn_end),
      .tmo_code_i   (code),
      .disc_o       (disc),
      .busy_o       (busy)
   );

   // Vector: start code, code applied after start, stop cycle (0 none),
   // stop kind (1 first data, 2 end), expected disconnect cycle (0 none).
   localparam int NVEC = 10;
   localparam logic [25:0] VEC [NVEC] = '{
      {3'd1, 3'd1, 9'd0,  2'd0, 9'd32 },  // R3 shortest
      {3'd7, 3'd7, 9'd0,  2'd0, 9'd224},  // R3 longest
      {3'd3, 3'd3, 9'd0,  2'd0, 9'd96 },  // R3
      {3'd0, 3'd0, 9'd0,  2'd0, 9'd0  },  // R2 disabled
      {3'd2, 3'd2, 9'd10, 2'd1, 9'd0  },  // R5 early first data
      {3'd2, 3'd2, 9'd63, 2'd2, 9'd0  },  // R6 end one before expiry
      {3'd2, 3'd2, 9'd64, 2'd1, 9'd0  },  // R9 stop on expiry edge
      {3'd2, 3'd2, 9'd65, 2'd1, 9'd64 },  // R4 stop one after expiry
      {3'd1, 3'd7, 9'd0,  2'd0, 9'd32 },  // R7 code raised later
      {3'd4, 3'd0, 9'd0,  2'd0, 9'd128}   // R7 code cleared later
   };

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic run_vec(input logic [25:0] v);
      logic [2:0] c0, c1;
      int stop_at, kind, exp, dcnt, dat;
      c0 = v[25:23]; c1 = v[22:20];
      stop_at = int'(v[19:11]); kind = int'(v[10:9]); exp = int'(v[8:0]);
      txn_start = 1'b1; code = c0;
      step();
      txn_start = 1'b0;
      check(busy == (c0 != 3'd0), "R2/R3 busy after start", int'(busy), int'(c0 != 3'd0));
      dcnt = 0; dat = 0;
      for (int k = 1; k <= 240; k++) begin
         if (k == 1) code = c1;
         if (k == stop_at) begin
            if (kind == 1) first_done = 1'b1;
            else           txn_end    = 1'b1;
         end
         step();
         first_done = 1'b0; txn_end = 1'b0;
         if (disc) begin
            dcnt++;
            if (dat == 0) dat = k;
            check(!busy, "R4 busy low with disconnect", int'(busy), 0);
         end
         if (k == stop_at && exp == 0 && c0 != 3'd0)
            check(!busy, "R5/R6/R9 busy after stop", int'(busy), 0);
      end
      check(dcnt == (exp != 0 ? 1 : 0), "R3/R4 disconnect count", dcnt, exp != 0 ? 1 : 0);
      check(dat == exp, "R3/R7/R9 disconnect cycle", dat, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      int dcnt, dat;
      rst = 1'b1; txn_start = 1'b0; first_done = 1'b0; txn_end = 1'b0; code = 3'd0;
      step(); step();
      check(!busy && !disc, "R1 reset state", int'(busy) + 2 * int'(disc), 0);
      rst = 1'b0;
      step();

      for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

      // R1: reset in the middle of a count drops the deadline
      txn_start = 1'b1; code = 3'd1;
      step();
      txn_start = 1'b0;
      repeat (10) step();
      rst = 1'b1;
      step();
      rst = 1'b0;
      check(!busy, "R1 busy after mid-count reset", int'(busy), 0);
      dcnt = 0;
      for (int k = 0; k < 40; k++) begin step(); if (disc) dcnt++; end
      check(dcnt == 0, "R1 no disconnect after reset", dcnt, 0);

      // R8: restart while armed uses new code from zero
      txn_start = 1'b1; code = 3'd1;
      step();
      txn_start = 1'b0;
      dcnt = 0; dat = 0;
      for (int k = 1; k <= 120; k++) begin
         if (k == 20) begin txn_start = 1'b1; code = 3'd2; end
         step();
         txn_start = 1'b0;
         if (disc) begin dcnt++; if (dat == 0) dat = k; end
      end
      check(dcnt == 1, "R8 single disconnect after restart", dcnt, 1);
      check(dat == 84, "R8 restart disconnect cycle", dat, 84);

      // R10: start and first-data strobe on the same edge
      txn_start = 1'b1; first_done = 1'b1; code = 3'd1;
      step();
      txn_start = 1'b0; first_done = 1'b0;
      check(busy, "R10 armed despite coincident stop", int'(busy), 1);
      dcnt = 0; dat = 0;
      for (int k = 1; k <= 40; k++) begin
         step();
         if (disc) begin dcnt++; if (dat == 0) dat = k; end
      end
      check(dat == 32 && dcnt == 1, "R10 disconnect cycle", dat, 32);

      summary();
      $finish;
   end

endmodule